// File: doc/BRIEF.md
# LIN Transmitter with Per-Bit Readback Error Detection

This block serialises bytes onto a single-wire LIN bus as 8N1 characters and, at the same time, reads its own line back through the receive pin. A transceiver that loops the bus level back to RXD lets the block compare every bit it drives with what the bus really carries. A mismatch is flagged inside the bit where it happens, instead of once the character is complete. Bit timing comes from an external oversampling tick that pulses sixteen times per bit.

Software writes one byte at a time into a one-deep holding register and watches an empty flag. Four static controls shape the error handling. One turns checking on. One picks an early or a late comparison point, to suit slow bus edges. One forces the rest of a damaged character to the recessive level. One keeps the frame running after an error, for debug. The transmit enable works as a queue control: dropping it lets the current character finish, and pulsing it low and high inside a character inserts one all-ones idle character.

Top module: `lin_fbe_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1 and `bit_err` is 0.
- R2: With `tx_en` high and a byte held, the next `rt_tick` starts a character. The character is a start bit of 0, eight data bits LSB first, then a stop bit of 1, each bit lasting 16 ticks and driven from that bit's first tick. `txd` changes only on edges where `rt_tick` is high. A write clears `tx_empty`, and moving the byte into the shifter sets it. A byte already held when a stop bit ends starts the next character with no gap.
- R3: The comparison runs only while a data character (not an idle character) is being sent and `det_en` is 1. Otherwise a mismatch never sets `bit_err`.
- R4: `rxd` passes through a two-flop synchroniser. It is compared with `txd` on the 9th tick of the bit, or on the 13th when `late_sample` is 1.
- R5: A mismatch sets `bit_err` within the same bit time.
- R6: `bit_err` stays set until a one-cycle `err_clr` pulse. A mismatch in the same cycle as `err_clr` leaves it set.
- R7: With `stop_on_err` at 0, the rest of the character after a mismatch is sent unchanged. With it at 1, every bit after the errored one is driven as 1.
- R8: With `dbg_keep` at 0, a mismatch aborts the frame. At the end of the current character the held byte is dropped, `tx_empty` goes to 1 and the line stays idle.
- R9: With `dbg_keep` at 1, a mismatch does not abort, and a held byte is sent next.
- R10: Clearing `tx_en` during a character lets that character finish, after which `txd` stays 1.
- R11: Clearing and then setting `tx_en` within one character queues one idle character (10 bit times of 1) before the held byte is sent.
- R12: If `tx_en` is still 0 when the stop bit ends, the held byte is discarded and `tx_empty` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Load `wr_data` into the holding register |
| wr_data | input | DATA_W | Byte to send |
| tx_empty | output | 1 | Holding register is empty |
| tx_en | input | 1 | Transmit enable |
| det_en | input | 1 | Enable bit-level readback comparison |
| stop_on_err | input | 1 | Drive 1s for the rest of an errored character |
| late_sample | input | 1 | Compare at tick 13 instead of tick 9 |
| dbg_keep | input | 1 | Do not abort the frame on an error |
| err_clr | input | 1 | One-cycle clear of `bit_err` |
| rxd | input | 1 | Bus level read back from the transceiver |
| txd | output | 1 | Serial output, idle 1 |
| bit_err | output | 1 | Sticky bit-error flag |

## Verification
The checker assumes `rt_tick` is a single-cycle pulse at least three clocks apart, so that a change on `txd` reaches the synchroniser output before the next tick. It also assumes the control inputs are steady around a comparison tick. The stimulus runs the tick every fourth clock and changes controls only between characters. The one exception is `tx_en`, which is toggled in mid-character on purpose. Errors are injected by inverting the loop-back for one whole bit, so each mismatch holds across both possible sample points.

// File: rtl/lin_fbe_pkg.sv
package lin_fbe_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_FRAME = 2'd1,
    TX_GAP   = 2'd2
  } tx_state_e;
endpackage

// File: rtl/lin_fbe_sync.sv
module lin_fbe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lin_fbe_bitcomp.sv
module lin_fbe_bitcomp #(
  parameter int OVS        = 16,
  parameter int EARLY_TICK = 9,
  parameter int LATE_TICK  = 13,
  parameter int PH_W       = $clog2(OVS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rt_tick,
  input  logic            frame_busy,
  input  logic            det_en,
  input  logic            late_sample,
  input  logic [PH_W-1:0] ph,
  input  logic            txd,
  input  logic            rxd_s,
  input  logic            err_clr,
  output logic            err_hit,
  output logic            bit_err
);
  // ph holds the tick count already elapsed in the bit; the tick that
  // sees ph == N-1 is the N-th tick of the bit.
  localparam logic [PH_W-1:0] EARLY_PH = PH_W'(EARLY_TICK - 1);
  localparam logic [PH_W-1:0] LATE_PH  = PH_W'(LATE_TICK - 1);

  logic [PH_W-1:0] cmp_ph;

  assign cmp_ph  = late_sample ? LATE_PH : EARLY_PH;
  assign err_hit = rt_tick & frame_busy & det_en & (ph == cmp_ph) & (rxd_s != txd);

  always_ff @(posedge clk) begin
    if (rst)          bit_err <= 1'b0;
    else if (err_hit) bit_err <= 1'b1;
    else if (err_clr) bit_err <= 1'b0;
  end
endmodule

// File: rtl/lin_fbe_txseq.sv
module lin_fbe_txseq
  import lin_fbe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int PH_W   = $clog2(OVS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_tick,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_hit,
  input  logic              stop_on_err,
  input  logic              dbg_keep,
  output logic              txd,
  output logic              tx_empty,
  output logic              frame_busy,
  output logic [PH_W-1:0]   ph
);
  localparam int BIT_N = DATA_W + 2;
  localparam int BIT_W = $clog2(BIT_N);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BIT_N - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(OVS);
  localparam logic [PH_W-1:0]  PH_FIRST  = PH_W'(1);

  tx_state_e         state;
  logic [BIT_W-1:0]  bidx;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] hold;
  logic              force_one;
  logic              abort_q;
  logic              gap_req;
  logic              char_end;
  logic              frame_stop;
  logic              launch;

  assign char_end   = rt_tick && (state != TX_IDLE) && (ph == PH_LAST) && (bidx == BIT_LAST);
  assign frame_stop = (state == TX_FRAME) && (abort_q || gap_req);
  assign launch     = rt_tick && tx_en && !tx_empty &&
                      ((state == TX_IDLE) || (char_end && !frame_stop));
  assign frame_busy = (state == TX_FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      bidx      <= '0;
      ph        <= '0;
      shreg     <= '0;
      hold      <= '0;
      tx_empty  <= 1'b1;
      txd       <= 1'b1;
      force_one <= 1'b0;
      abort_q   <= 1'b0;
      gap_req   <= 1'b0;
    end else begin
      if (err_hit) begin
        if (stop_on_err) force_one <= 1'b1;
        if (!dbg_keep)   abort_q   <= 1'b1;
      end
      if (state == TX_FRAME && !tx_en) gap_req <= 1'b1;

      if (launch) begin
        state     <= TX_FRAME;
        ph        <= PH_FIRST;
        bidx      <= '0;
        shreg     <= hold;
        tx_empty  <= 1'b1;
        txd       <= 1'b0;
        force_one <= 1'b0;
        abort_q   <= 1'b0;
        gap_req   <= 1'b0;
      end else if (char_end) begin
        txd       <= 1'b1;
        ph        <= PH_FIRST;
        bidx      <= '0;
        force_one <= 1'b0;
        abort_q   <= 1'b0;
        gap_req   <= 1'b0;
        if (state == TX_FRAME && gap_req && !abort_q && tx_en) state <= TX_GAP;
        else                                                   state <= TX_IDLE;
        if (state == TX_FRAME && (abort_q || !tx_en)) tx_empty <= 1'b1;
      end else if (rt_tick && state != TX_IDLE) begin
        if (ph != PH_LAST) begin
          ph <= ph + 1'b1;
        end else begin
          ph   <= PH_FIRST;
          bidx <= bidx + 1'b1;
          if (bidx == DATA_LAST) begin
            txd <= 1'b1;
          end else begin
            txd   <= (state == TX_GAP) || force_one || shreg[0];
            shreg <= shreg >> 1;
          end
        end
      end

      if (wr_en) begin
        hold     <= wr_data;
        tx_empty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lin_fbe_tx.sv
module lin_fbe_tx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EARLY_TICK  = 9,
  parameter int LATE_TICK   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  input  logic              tx_en,
  input  logic              det_en,
  input  logic              stop_on_err,
  input  logic              late_sample,
  input  logic              dbg_keep,
  input  logic              err_clr,
  input  logic              rxd,
  output logic              txd,
  output logic              bit_err
);
  localparam int PH_W = $clog2(OVS + 1);

  logic            rxd_s;
  logic            err_hit;
  logic            frame_busy;
  logic [PH_W-1:0] ph;

  lin_fbe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
  );

  lin_fbe_txseq #(.DATA_W(DATA_W), .OVS(OVS), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst(rst), .rt_tick(rt_tick), .tx_en(tx_en),
    .wr_en(wr_en), .wr_data(wr_data), .err_hit(err_hit),
    .stop_on_err(stop_on_err), .dbg_keep(dbg_keep),
    .txd(txd), .tx_empty(tx_empty), .frame_busy(frame_busy), .ph(ph)
  );

  lin_fbe_bitcomp #(.OVS(OVS), .EARLY_TICK(EARLY_TICK), .LATE_TICK(LATE_TICK), .PH_W(PH_W)) u_cmp (
    .clk(clk), .rst(rst), .rt_tick(rt_tick), .frame_busy(frame_busy),
    .det_en(det_en), .late_sample(late_sample), .ph(ph), .txd(txd),
    .rxd_s(rxd_s), .err_clr(err_clr), .err_hit(err_hit), .bit_err(bit_err)
  );
endmodule

// File: rtl/lin_fbe_tx_chk.sv
module lin_fbe_tx_chk (
  input logic clk,
  input logic rst,
  input logic rt_tick,
  input logic det_en,
  input logic err_clr,
  input logic err_hit,
  input logic frame_busy,
  input logic bit_err,
  input logic txd
);
  p_txd_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(rt_tick));

  p_no_flag_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!det_en && !bit_err) |=> !bit_err);

  p_no_flag_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!frame_busy && !bit_err) |=> !bit_err);

  p_flag_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_err) |-> $past(rt_tick));

  p_hit_sets_r5: assert property (@(posedge clk) disable iff (rst)
    err_hit |=> bit_err);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_err && !err_clr) |=> bit_err);

  p_clear_works_r6: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !err_hit) |=> !bit_err);
endmodule

bind lin_fbe_tx lin_fbe_tx_chk u_chk (
  .clk(clk), .rst(rst), .rt_tick(rt_tick), .det_en(det_en),
  .err_clr(err_clr), .err_hit(err_hit), .frame_busy(frame_busy),
  .bit_err(bit_err), .txd(txd)
);

// File: tb/tb_lin_fbe_tx.sv
module tb_lin_fbe_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] tdiv = 2'd0;
  logic       rt_tick;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_empty;
  logic       tx_en = 1'b1;
  logic       det_en = 1'b1;
  logic       stop_on_err = 1'b0;
  logic       late_sample = 1'b0;
  logic       dbg_keep = 1'b1;
  logic       err_clr = 1'b0;
  logic       inj = 1'b0;
  logic       rxd;
  logic       txd;
  logic       bit_err;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign rt_tick = (tdiv == 2'd3);
  assign rxd = txd ^ inj;

  lin_fbe_tx dut (
    .clk(clk), .rst(rst), .rt_tick(rt_tick), .wr_en(wr_en), .wr_data(wr_data),
    .tx_empty(tx_empty), .tx_en(tx_en), .det_en(det_en), .stop_on_err(stop_on_err),
    .late_sample(late_sample), .dbg_keep(dbg_keep), .err_clr(err_clr),
    .rxd(rxd), .txd(txd), .bit_err(bit_err)
  );

  function automatic logic [9:0] exp_frame(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  function automatic logic [9:0] exp_forced(input logic [7:0] d, input int k);
    logic [9:0] f = exp_frame(d);
    for (int i = 0; i < 10; i++) if (i > k) f[i] = 1'b1;
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic wait_fall(input int lim, output int n);
    n = 0;
    while (txd !== 1'b0 && n < lim) begin @(negedge clk); n++; end
  endtask

  // Starts at the negedge right after a start bit fell; ends one negedge
  // past the stop bit (t = 640 clocks).
  task automatic capture(input int err_bit, input logic wr_nxt, input logic [7:0] nxt,
                         input int en_mode, output logic [9:0] bits,
                         output logic e0, output logic e40, output logic e60);
    bits = '0; e0 = 1'b0; e40 = 1'b0; e60 = 1'b0;
    for (int b = 0; b < 10; b++) begin
      for (int c = 0; c < 64; c++) begin
        inj = (b == err_bit) && (c >= 1) && (c <= 62);
        if (b == 0 && c == 2 && wr_nxt) begin wr_en = 1'b1; wr_data = nxt; end
        if (b == 0 && c == 3) wr_en = 1'b0;
        if (en_mode != 0 && b == 3 && c == 10) tx_en = 1'b0;
        if (en_mode == 1 && b == 5 && c == 10) tx_en = 1'b1;
        if (c == 32) bits[b] = txd;
        if (b == err_bit && c == 0)  e0  = bit_err;
        if (b == err_bit && c == 40) e40 = bit_err;
        if (b == err_bit && c == 60) e60 = bit_err;
        @(negedge clk);
      end
    end
    inj = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [9:0] bits;
    logic e0, e40, e60;
    logic [7:0] a, b2;
    int n;
    void'($urandom(32'h1A5C));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd", {31'd0, txd}, 32'd1);
    chk("R1 tx_empty", {31'd0, tx_empty}, 32'd1);
    chk("R1 bit_err", {31'd0, bit_err}, 32'd0);

    // random clean frames under random control settings
    for (int i = 0; i < 6; i++) begin
      a = 8'($urandom);
      det_en = 1'($urandom); late_sample = 1'($urandom);
      stop_on_err = 1'($urandom); dbg_keep = 1'($urandom);
      write_byte(a);
      chk("R2 write clears empty", {31'd0, tx_empty}, 32'd0);
      wait_fall(100, n);
      chk("R2 start within a tick", {31'd0, n < 8}, 32'd1);
      capture(-1, 1'b0, 8'h00, 0, bits, e0, e40, e60);
      chk("R2 frame bits", {22'd0, bits}, {22'd0, exp_frame(a)});
      chk("R2 empty after load", {31'd0, tx_empty}, 32'd1);
      chk("R3 no false error", {31'd0, bit_err}, 32'd0);
    end
    det_en = 1'b1; late_sample = 1'b0; stop_on_err = 1'b0; dbg_keep = 1'b1;

    // back-to-back
    a = 8'($urandom); b2 = 8'($urandom);
    write_byte(a); wait_fall(100, n);
    capture(-1, 1'b1, b2, 0, bits, e0, e40, e60);
    chk("R2 first of pair", {22'd0, bits}, {22'd0, exp_frame(a)});
    wait_fall(2000, n);
    chk("R2 no gap", n, 0);
    capture(-1, 1'b0, 8'h00, 0, bits, e0, e40, e60);
    chk("R2 second of pair", {22'd0, bits}, {22'd0, exp_frame(b2)});

    // early sample, no forcing, debug keep
    write_byte(8'hA5); wait_fall(100, n);
    capture(4, 1'b1, 8'h3C, 0, bits, e0, e40, e60);
    chk("R7 rest unchanged", {22'd0, bits}, {22'd0, exp_frame(8'hA5)});
    chk("R5 clear before bit", {31'd0, e0}, 32'd0);
    chk("R4 early tick flag", {31'd0, e40}, 32'd1);
    chk("R5 set in bit", {31'd0, e60}, 32'd1);
    wait_fall(2000, n);
    chk("R9 no abort", n, 0);
    capture(-1, 1'b0, 8'h00, 0, bits, e0, e40, e60);
    chk("R9 held byte sent", {22'd0, bits}, {22'd0, exp_frame(8'h3C)});
    chk("R6 sticky", {31'd0, bit_err}, 32'd1);
    pulse_clr();
    chk("R6 cleared", {31'd0, bit_err}, 32'd0);

    // late sample point
    late_sample = 1'b1;
    write_byte(8'h5A); wait_fall(100, n);
    capture(6, 1'b0, 8'h00, 0, bits, e0, e40, e60);
    chk("R4 late tick not yet", {31'd0, e40}, 32'd0);
    chk("R5 late set in bit", {31'd0, e60}, 32'd1);
    pulse_clr();
    late_sample = 1'b0;

    // forcing plus abort
    stop_on_err = 1'b1; dbg_keep = 1'b0;
    write_byte(8'h00); wait_fall(100, n);
    capture(3, 1'b1, 8'h77, 0, bits, e0, e40, e60);
    chk("R7 forced ones", {22'd0, bits}, {22'd0, exp_forced(8'h00, 3)});
    chk("R8 held byte dropped", {31'd0, tx_empty}, 32'd1);
    wait_fall(300, n);
    chk("R8 line idle", n, 300);
    pulse_clr();
    stop_on_err = 1'b0; dbg_keep = 1'b1;

    // detection off
    det_en = 1'b0;
    write_byte(8'hC3); wait_fall(100, n);
    capture(2, 1'b0, 8'h00, 0, bits, e0, e40, e60);
    chk("R3 off no flag", {31'd0, e60}, 32'd0);
    chk("R3 off bits", {22'd0, bits}, {22'd0, exp_frame(8'hC3)});
    det_en = 1'b1;

    // enable toggled within a character -> idle character queued
    write_byte(8'h96); wait_fall(100, n);
    capture(-1, 1'b1, 8'h69, 1, bits, e0, e40, e60);
    chk("R10 frame completes", {22'd0, bits}, {22'd0, exp_frame(8'h96)});
    wait_fall(2000, n);
    chk("R11 idle char length", n, 640);
    capture(-1, 1'b0, 8'h00, 0, bits, e0, e40, e60);
    chk("R11 held byte after idle", {22'd0, bits}, {22'd0, exp_frame(8'h69)});

    // enable still low at stop bit end -> held byte discarded
    write_byte(8'h81); wait_fall(100, n);
    capture(-1, 1'b1, 8'h18, 2, bits, e0, e40, e60);
    chk("R10 completes when disabled", {22'd0, bits}, {22'd0, exp_frame(8'h81)});
    chk("R12 empty after discard", {31'd0, tx_empty}, 32'd1);
    wait_fall(200, n);
    chk("R10 idle while disabled", n, 200);
    tx_en = 1'b1;
    wait_fall(300, n);
    chk("R12 nothing sent on restore", n, 300);

    summary();
    $finish;
  end
endmodule